// File: doc/BRIEF.md
# Paired-Page Translation Lookup Buffer

This block translates 32-bit virtual addresses to physical addresses over 4 KB pages. It holds a parameterised number of entries, and software loads them one at a time by index. Each entry covers two consecutive virtual pages. Bits 31:13 of the address form the tag, and bit 12 selects the even or the odd half. Each half has its own frame number, valid bit and dirty bit. An entry takes part in a match when its tag is equal to the address tag and one of two conditions holds: its global bit is set, or its stored address-space identifier is equal to the current one.

The lookup is combinational. In the same cycle the block gives a hit flag, the physical address and a two-bit fault class. A registered copy of the hit flag is available one cycle later. The processor's exception logic uses the fault class to choose between a refill fault, an invalid-page fault and a modified-page fault.

Top module: `tlb_lookup`

## Requirements
- R1: After reset every entry is all-zero (tag 0, identifier 0, global 0, both halves invalid), and `hit_q_o` is 0.
- R2: An entry with its global bit clear matches only when its tag equals `va_i[31:13]` and its stored identifier equals `asid_i`.
- R3: An entry with its global bit set matches on tag alone, for any `asid_i`.
- R4: On a hit, `va_i[12]` selects the half (0 = even, 1 = odd), and `pa_o` = {selected frame number, `va_i[11:0]`}.
- R5: A match whose selected half has its valid bit clear gives `fault_o` = 2 (invalid). This holds for reads and writes, `hit_o` is 0 and `pa_o` is 0.
- R6: A write (`is_write_i` = 1) that matches a valid half with its dirty bit clear gives `fault_o` = 3 (modified), `hit_o` 0 and `pa_o` 0. A read of the same half is a hit.
- R7: When no entry matches, `fault_o` = 1 (miss), `hit_o` is 0 and `pa_o` is 0. A hit gives `fault_o` = 0.
- R8: When several entries match, the lowest-indexed entry supplies the result.
- R9: A write-port strobe replaces the entry at `wr_idx_i` at the next clock edge. The next cycle's lookup sees the new contents, and no other entry changes.
- R10: `hit_q_o` equals `hit_o` from the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| va_i | input | 32 | Virtual address to translate |
| is_write_i | input | 1 | 1 for a store access |
| asid_i | input | 8 | Current address-space identifier |
| hit_o | output | 1 | Translation succeeded this cycle |
| pa_o | output | 32 | Physical address, 0 unless hit |
| fault_o | output | 2 | 0 none, 1 miss, 2 invalid, 3 modified |
| hit_q_o | output | 1 | Registered `hit_o` |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_vpn_i | input | 19 | Tag (page-pair number) |
| wr_asid_i | input | 8 | Stored identifier |
| wr_global_i | input | 1 | Global bit |
| wr_pfn0_i | input | 20 | Even-page frame number |
| wr_v0_i | input | 1 | Even-page valid |
| wr_d0_i | input | 1 | Even-page dirty |
| wr_pfn1_i | input | 20 | Odd-page frame number |
| wr_v1_i | input | 1 | Odd-page valid |
| wr_d1_i | input | 1 | Odd-page dirty |

## Verification
The test loads entries that share a tag but differ in identifier, then looks up that tag under several identifiers. The outcome shows whether identifier gating works and whether the lowest index wins. Pairs of accesses to the even and odd halves check the half selection. Read/write pairs on a clean page, and on a page that is invalid but matches, check that each fault class is told apart from a hit and from a miss. A global entry is probed under unrelated identifiers. Overwriting the winning entry checks both the write port and the fallback to the next matching index.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 19;
  localparam int PFN_W  = 20;
  localparam int ASID_W = 8;
  localparam int OFF_W  = 12;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glb;
    logic [PFN_W-1:0]  pfn0;
    logic              v0;
    logic              d0;
    logic [PFN_W-1:0]  pfn1;
    logic              v1;
    logic              d1;
  } tlb_entry_t;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_MISS     = 2'd1,
    FLT_INVALID  = 2'd2,
    FLT_MODIFIED = 2'd3
  } fault_e;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  tlb_entry_t       wr_entry_i,
  output tlb_entry_t       entries_o [NUM_ENTRIES]
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    tlb_entry_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ent_q <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))    ent_q <= wr_entry_i;
    end
    assign entries_o[g] = ent_q;
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  tlb_entry_t        entries_i [NUM_ENTRIES],
  input  logic [VPN_W-1:0]  tag_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic [NUM_ENTRIES-1:0] match_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign match_o[g] = (entries_i[g].vpn == tag_i) &&
                        (entries_i[g].glb || (entries_i[g].asid == asid_i));
  end
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0] req_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o
);
  // scan downward so the lowest set index is the last assignment
  always_comb begin
    idx_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       va_i,
  input  logic              is_write_i,
  input  logic [7:0]        asid_i,
  output logic              hit_o,
  output logic [31:0]       pa_o,
  output logic [1:0]        fault_o,
  output logic              hit_q_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [18:0]       wr_vpn_i,
  input  logic [7:0]        wr_asid_i,
  input  logic              wr_global_i,
  input  logic [19:0]       wr_pfn0_i,
  input  logic              wr_v0_i,
  input  logic              wr_d0_i,
  input  logic [19:0]       wr_pfn1_i,
  input  logic              wr_v1_i,
  input  logic              wr_d1_i
);
  tlb_entry_t             entries [NUM_ENTRIES];
  tlb_entry_t             wr_entry;
  logic [NUM_ENTRIES-1:0] match;
  logic                   any_match;
  logic [IDX_W-1:0]       sel_idx;
  tlb_entry_t             sel;
  logic [PFN_W-1:0]       pfn;
  logic                   pg_v, pg_d;
  fault_e                 fault;

  assign wr_entry = '{vpn: wr_vpn_i, asid: wr_asid_i, glb: wr_global_i,
                      pfn0: wr_pfn0_i, v0: wr_v0_i, d0: wr_d0_i,
                      pfn1: wr_pfn1_i, v1: wr_v1_i, d1: wr_d1_i};

  tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i,
    .wr_entry_i (wr_entry),
    .entries_o  (entries)
  );

  tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .entries_i (entries),
    .tag_i     (va_i[31:13]),
    .asid_i    (asid_i),
    .match_o   (match)
  );

  tlb_prio_sel #(.NUM_ENTRIES(NUM_ENTRIES)) u_prio (
    .req_i (match),
    .any_o (any_match),
    .idx_o (sel_idx)
  );

  assign sel  = entries[sel_idx];
  assign pfn  = va_i[12] ? sel.pfn1 : sel.pfn0;
  assign pg_v = va_i[12] ? sel.v1   : sel.v0;
  assign pg_d = va_i[12] ? sel.d1   : sel.d0;

  always_comb begin
    if (!any_match)              fault = FLT_MISS;
    else if (!pg_v)              fault = FLT_INVALID;
    else if (is_write_i && !pg_d) fault = FLT_MODIFIED;
    else                         fault = FLT_NONE;
  end

  assign fault_o = fault;
  assign hit_o   = (fault == FLT_NONE);
  assign pa_o    = hit_o ? {pfn, va_i[OFF_W-1:0]} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q_o <= 1'b0;
    else         hit_q_o <= hit_o;
  end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] va_i,
  input logic        is_write_i,
  input logic        hit_o,
  input logic [31:0] pa_o,
  input logic [1:0]  fault_o,
  input logic        hit_q_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_hitq_delay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> hit_q_o == $past(hit_o));

  assert_offset_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> pa_o[11:0] == va_i[11:0]);

  assert_mod_only_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o == 2'd3 |-> is_write_i);

  assert_miss_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o == 2'd1 |-> (!hit_o && pa_o == 32'd0));

  assert_invalid_nohit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o == 2'd2 |-> (!hit_o && pa_o == 32'd0));
endmodule

bind tlb_lookup tlb_lookup_chk u_chk (.*);

// File: tb/tlb_lookup_bench.sv
module tlb_lookup_bench;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  typedef struct packed {
    logic [18:0] vpn;
    logic        odd;
    logic [11:0] off;
    logic        wr;
    logic [7:0]  asid;
    logic [1:0]  fault;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{19'h12345, 1'b0, 12'h123, 1'b0, 8'h05, 2'd0, 32'h00AAA123}, // R2 R4 R8
    '{19'h12345, 1'b1, 12'h456, 1'b0, 8'h05, 2'd0, 32'h00BBB456}, // R4 odd
    '{19'h12345, 1'b1, 12'h456, 1'b1, 8'h05, 2'd3, 32'h0},        // R6
    '{19'h12345, 1'b0, 12'h123, 1'b1, 8'h05, 2'd0, 32'h00AAA123}, // R6 dirty ok
    '{19'h12345, 1'b0, 12'hABC, 1'b0, 8'h07, 2'd0, 32'h44444ABC}, // R2 other asid
    '{19'h12345, 1'b0, 12'h123, 1'b0, 8'h09, 2'd1, 32'h0},        // R2 no asid
    '{19'h22222, 1'b1, 12'h0FF, 1'b0, 8'h09, 2'd0, 32'h333330FF}, // R3
    '{19'h22222, 1'b0, 12'h001, 1'b0, 8'h42, 2'd2, 32'h0},        // R5 read
    '{19'h22222, 1'b0, 12'h001, 1'b1, 8'h42, 2'd2, 32'h0},        // R5 write
    '{19'h7FFFF, 1'b0, 12'h000, 1'b0, 8'h00, 2'd1, 32'h0}         // R7
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] va = '0;
  logic        is_wr = 1'b0;
  logic [7:0]  asid = '0;
  logic        hit, hit_q;
  logic [31:0] pa;
  logic [1:0]  fault;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [18:0]   wr_vpn = '0;
  logic [7:0]    wr_asid = '0;
  logic          wr_g = 1'b0;
  logic [19:0]   wr_pfn0 = '0, wr_pfn1 = '0;
  logic          wr_v0 = 1'b0, wr_d0 = 1'b0, wr_v1 = 1'b0, wr_d1 = 1'b0;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  tlb_lookup #(.NUM_ENTRIES(N)) u_tlb_lookup (
    .clk_i(clk), .rst_ni(rst_n), .va_i(va), .is_write_i(is_wr), .asid_i(asid),
    .hit_o(hit), .pa_o(pa), .fault_o(fault), .hit_q_o(hit_q),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vpn_i(wr_vpn), .wr_asid_i(wr_asid),
    .wr_global_i(wr_g), .wr_pfn0_i(wr_pfn0), .wr_v0_i(wr_v0), .wr_d0_i(wr_d0),
    .wr_pfn1_i(wr_pfn1), .wr_v1_i(wr_v1), .wr_d1_i(wr_d1)
  );

  task automatic check(input string req, input logic [1:0] ef, input logic [31:0] ep);
    n_run++;
    if (fault !== ef || pa !== ep || hit !== (ef == 2'd0)) begin
      n_fail++;
      $display("FAIL %s: fault=%0d pa=%h hit=%b expected fault=%0d pa=%h hit=%b",
               req, fault, pa, hit, ef, ep, ef == 2'd0);
    end
  endtask

  task automatic look(input logic [18:0] vpn, input logic odd, input logic [11:0] off,
                      input logic w, input logic [7:0] a);
    @(negedge clk);
    va = {vpn, odd, off}; is_wr = w; asid = a;
    #1;
  endtask

  task automatic load(input int idx, input logic [18:0] vpn, input logic [7:0] a, input logic g,
                      input logic [19:0] p0, input logic v0, input logic d0,
                      input logic [19:0] p1, input logic v1, input logic d1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_vpn = vpn; wr_asid = a; wr_g = g;
    wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0; wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    look(19'h12345, 1'b0, 12'h123, 1'b0, 8'h05);
    check("R1 empty after reset", 2'd1, 32'h0);
    n_run++;
    if (hit_q !== 1'b0) begin
      n_fail++; $display("FAIL R1: hit_q=%b expected 0", hit_q);
    end
    // zero entries match tag 0 / asid 0 but are invalid
    look(19'h0, 1'b1, 12'h010, 1'b0, 8'h00);
    check("R1 zero entry invalid", 2'd2, 32'h0);

    load(0, 19'h12345, 8'h05, 1'b0, 20'h00AAA, 1'b1, 1'b1, 20'h00BBB, 1'b1, 1'b0);
    load(1, 19'h22222, 8'h00, 1'b1, 20'h11111, 1'b0, 1'b0, 20'h33333, 1'b1, 1'b1);
    load(2, 19'h12345, 8'h07, 1'b0, 20'h44444, 1'b1, 1'b1, 20'h55555, 1'b1, 1'b1);
    load(3, 19'h12345, 8'h05, 1'b0, 20'h66666, 1'b1, 1'b1, 20'h66666, 1'b1, 1'b1);

    for (int i = 0; i < NV; i++) begin
      look(VEC[i].vpn, VEC[i].odd, VEC[i].off, VEC[i].wr, VEC[i].asid);
      check($sformatf("R2-table vec %0d", i), VEC[i].fault, VEC[i].pa);
    end

    // R10: registered hit follows the previous cycle
    look(19'h12345, 1'b0, 12'h123, 1'b0, 8'h05);
    look(19'h7FFFF, 1'b0, 12'h000, 1'b0, 8'h00);
    n_run++;
    if (hit_q !== 1'b1) begin
      n_fail++; $display("FAIL R10: hit_q=%b expected 1", hit_q);
    end
    @(negedge clk);
    n_run++;
    if (hit_q !== 1'b0) begin
      n_fail++; $display("FAIL R10: hit_q=%b expected 0", hit_q);
    end

    // R9 and R8: retag entry 0, entry 3 now wins for the old tag
    load(0, 19'h01010, 8'h05, 1'b0, 20'h77777, 1'b1, 1'b1, 20'h77777, 1'b1, 1'b1);
    look(19'h12345, 1'b0, 12'h123, 1'b0, 8'h05);
    check("R8 R9 fallback to index 3", 2'd0, 32'h66666123);
    look(19'h01010, 1'b1, 12'hFED, 1'b1, 8'h05);
    check("R9 new contents", 2'd0, 32'h77777FED);
    look(19'h22222, 1'b1, 12'h0FF, 1'b0, 8'h05);
    check("R9 other entry intact", 2'd0, 32'h333330FF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule